// File: doc/BRIEF.md
# Undervoltage and Thermal Fault Supervisor

This block watches the health of a set of regulated output rails and of the main input supplies, together with two temperature comparator flags, and decides how the power system reacts. It drives one fault flag, a per-regulator disable vector, a device-wide latch-off and a request to move into the deepest sleep state.

Each output rail carries an undervoltage flag and an arm bit. A flag from a rail whose monitor is not yet armed is ignored. Every undervoltage flag, whether from an output or an input, must persist for a programmable number of clock cycles before it counts. The response then depends on the rail. A rail driven through an external pass element only raises the fault flag. A rail driven through an on-chip pass element also has its regulator latched off. A standby rail that fails before start-up completes latches off the whole device until power-on reset. The thermal path raises the fault at the warning level and shuts down every regulator at the critical level. It holds that shutdown until the warning flag clears. A lost main input during the active state requests a forced sleep. The shutdown input overrides all of this.

All interfaces are plain level signals sampled on the clock. No handshake is used, because every input is a status level and every output is a control level that downstream logic reads continuously.

Top module: `uvf_supervisor`

## Requirements
- R1: An armed output rail's undervoltage flag that stays high for PERSIST_CYC consecutive clock edges raises fault_o after the PERSIST_CYC-th edge. A run one edge shorter raises nothing. When the flag drops, fault_o falls after the next edge, provided no other cause is present.
- R2: An undervoltage flag on a rail whose out_armed_i bit is 0 has no effect on any output.
- R3: A persistent fault on a rail whose INT_PASS bit is 0 (external pass element) raises fault_o but never sets that rail's reg_off_o bit.
- R4: A persistent fault on a rail whose INT_PASS bit is 1 sets that rail's reg_off_o bit one edge after fault_o rises. The bit stays set after the flag clears, until shutdown.
- R5: A persistent fault on a rail whose SB_MASK bit is 1, while startup_done_i is 0 and shutdown is low, sets latch_off_o one edge after the fault. Only rst_n clears it. While latch_off_o is high, fault_o (outside shutdown) and every reg_off_o bit are high.
- R6: temp_warn_i high raises fault_o after one edge and disables no regulator.
- R7: temp_crit_i high sets every reg_off_o bit after one edge. The shutdown holds while temp_warn_i stays high and releases one edge after temp_warn_i falls.
- R8: Any input undervoltage flag that persists for PERSIST_CYC edges while active_i is 1 sets force_s5_o (and fault_o) one edge later. force_s5_o then holds regardless of active_i until all input flags clear. Input flags that persist while active_i is 0 and force_s5_o is low have no effect.
- R9: shdn_i high forces fault_o low in the same cycle and drives every reg_off_o bit high. It clears the per-regulator latches and force_s5_o at the next edge.
- R10: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| shdn_i | input | 1 | Global shutdown request |
| active_i | input | 1 | 1 = active state, 0 = sleep state |
| startup_done_i | input | 1 | All rails have finished their first ramp |
| out_uv_i | input | N_OUT | Per-output undervoltage flags |
| out_armed_i | input | N_OUT | Per-output monitor arm bits |
| in_uv_i | input | N_IN | Main input undervoltage flags |
| temp_warn_i | input | 1 | Die above warning temperature |
| temp_crit_i | input | 1 | Die above critical temperature |
| fault_o | output | 1 | Centralized fault flag |
| reg_off_o | output | N_OUT | Per-regulator disable |
| latch_off_o | output | 1 | Device-wide latch-off |
| force_s5_o | output | 1 | Request a forced move to deep sleep |

## Verification
The timing of each result is fixed, and the bench relies on it. A rail fault appears on fault_o PERSIST_CYC edges after the flag first rises. Regulator latches, latch_off_o and force_s5_o follow one edge after their filtered cause. The thermal effects follow one edge after the temperature flags. The shutdown effect on fault_o and reg_off_o takes hold in the same cycle. The bench drives inputs on the falling edge and runs its own cycle model from the requirements on the rising edge. It compares all four outputs at each following falling edge, so a result that is early or late by one edge shows up as a mismatch. Directed phases also check hand-computed values at the exact due cycle.

// File: rtl/uvf_pkg.sv
package uvf_pkg;
  typedef enum logic [1:0] {
    TH_NORMAL = 2'd0,
    TH_HOT    = 2'd1,
    TH_TRIP   = 2'd2
  } therm_e;

  function automatic int cnt_width(input int cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction
endpackage

// File: rtl/uvf_persist.sv
module uvf_persist #(
  parameter int PERSIST_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = uvf_pkg::cnt_width(PERSIST_CYC);
  localparam logic [CW-1:0] LAST = CW'(PERSIST_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      flt_o <= 1'b0;
    end else if (!raw_i) begin
      run_q <= '0;
      flt_o <= 1'b0;
    end else begin
      if (run_q != LAST) run_q <= run_q + 1'b1;
      flt_o <= (run_q == LAST);
    end
  end
endmodule

// File: rtl/uvf_thermal.sv
module uvf_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic crit_i,
  output logic flag_o,
  output logic trip_o
);
  import uvf_pkg::*;

  therm_e st_q, st_d;

  always_comb begin
    if (crit_i)                        st_d = TH_TRIP;
    else if (warn_i && st_q == TH_TRIP) st_d = TH_TRIP;
    else if (warn_i)                   st_d = TH_HOT;
    else                               st_d = TH_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TH_NORMAL;
    else        st_q <= st_d;
  end

  assign flag_o = (st_q != TH_NORMAL);
  assign trip_o = (st_q == TH_TRIP);
endmodule

// File: rtl/uvf_latches.sv
module uvf_latches #(
  parameter int               N_OUT    = 5,
  parameter logic [N_OUT-1:0] INT_PASS = '0,
  parameter logic [N_OUT-1:0] SB_MASK  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_i,
  input  logic             startup_done_i,
  input  logic             active_i,
  input  logic [N_OUT-1:0] out_flt_i,
  input  logic             in_any_i,
  output logic [N_OUT-1:0] reg_lat_o,
  output logic             latch_off_o,
  output logic             force_s5_o
);
  logic sb_hit;
  assign sb_hit = |(out_flt_i & SB_MASK);

  for (genvar g = 0; g < N_OUT; g++) begin : g_rail
    if (INT_PASS[g]) begin : g_int
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           reg_lat_o[g] <= 1'b0;
        else if (shdn_i)      reg_lat_o[g] <= 1'b0;
        else if (out_flt_i[g]) reg_lat_o[g] <= 1'b1;
      end
    end else begin : g_ext
      assign reg_lat_o[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_off_o <= 1'b0;
      force_s5_o  <= 1'b0;
    end else begin
      if (!shdn_i && !startup_done_i && sb_hit) latch_off_o <= 1'b1;
      if (shdn_i || !in_any_i) force_s5_o <= 1'b0;
      else if (active_i)       force_s5_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uvf_supervisor.sv
module uvf_supervisor #(
  parameter int               N_OUT       = 5,
  parameter int               N_IN        = 3,
  parameter int               PERSIST_CYC = 2500,
  parameter logic [N_OUT-1:0] INT_PASS    = 5'b01001,
  parameter logic [N_OUT-1:0] SB_MASK     = 5'b00101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_i,
  input  logic             active_i,
  input  logic             startup_done_i,
  input  logic [N_OUT-1:0] out_uv_i,
  input  logic [N_OUT-1:0] out_armed_i,
  input  logic [N_IN-1:0]  in_uv_i,
  input  logic             temp_warn_i,
  input  logic             temp_crit_i,
  output logic             fault_o,
  output logic [N_OUT-1:0] reg_off_o,
  output logic             latch_off_o,
  output logic             force_s5_o
);
  logic [N_OUT-1:0] out_raw, out_flt, reg_lat;
  logic [N_IN-1:0]  in_flt;
  logic             th_flag, th_trip, global_off;

  assign out_raw = out_uv_i & out_armed_i;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out_filt
    uvf_persist #(.PERSIST_CYC(PERSIST_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(out_raw[g]), .flt_o(out_flt[g]));
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_in_filt
    uvf_persist #(.PERSIST_CYC(PERSIST_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(in_uv_i[g]), .flt_o(in_flt[g]));
  end

  uvf_thermal u_therm (
    .clk(clk), .rst_n(rst_n), .warn_i(temp_warn_i), .crit_i(temp_crit_i),
    .flag_o(th_flag), .trip_o(th_trip));

  uvf_latches #(.N_OUT(N_OUT), .INT_PASS(INT_PASS), .SB_MASK(SB_MASK)) u_lat (
    .clk(clk), .rst_n(rst_n), .shdn_i(shdn_i), .startup_done_i(startup_done_i),
    .active_i(active_i), .out_flt_i(out_flt), .in_any_i(|in_flt),
    .reg_lat_o(reg_lat), .latch_off_o(latch_off_o), .force_s5_o(force_s5_o));

  assign global_off = shdn_i | latch_off_o | th_trip;
  assign reg_off_o  = reg_lat | {N_OUT{global_off}};
  assign fault_o    = !shdn_i & ((|out_flt) | latch_off_o | th_flag | force_s5_o);
endmodule

// File: rtl/uvf_supervisor_chk.sv
module uvf_supervisor_chk #(
  parameter int N_OUT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shdn_i,
  input logic             active_i,
  input logic [N_OUT-1:0] out_armed_i,
  input logic [N_OUT-1:0] out_flt,
  input logic             fault_o,
  input logic [N_OUT-1:0] reg_off_o,
  input logic             latch_off_o,
  input logic             force_s5_o
);
  p_shdn_fault_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |-> !fault_o);

  p_shdn_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |-> &reg_off_o);

  p_latch_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_off_o |=> latch_off_o);

  p_latch_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_off_o |-> (&reg_off_o && (shdn_i || fault_o)));

  p_s5_from_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_s5_o) |-> $past(active_i));

  p_s5_reports_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_s5_o && !shdn_i) |-> fault_o);

  for (genvar g = 0; g < N_OUT; g++) begin : g_arm
    p_unarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_armed_i[g] |=> !out_flt[g]);
  end
endmodule

bind uvf_supervisor uvf_supervisor_chk #(.N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .shdn_i(shdn_i), .active_i(active_i),
  .out_armed_i(out_armed_i), .out_flt(out_flt), .fault_o(fault_o),
  .reg_off_o(reg_off_o), .latch_off_o(latch_off_o), .force_s5_o(force_s5_o));

// File: tb/uvf_supervisor_tb_top.sv
`timescale 1ns/1ps
module uvf_supervisor_tb_top;
  localparam int NO = 5;
  localparam int NI = 3;
  localparam int P  = 6;
  localparam logic [NO-1:0] INTP = 5'b01001;
  localparam logic [NO-1:0] SBM  = 5'b00101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn = 1'b0, active = 1'b1, sdone = 1'b0, twarn = 1'b0, tcrit = 1'b0;
  logic [NO-1:0] ouv = '0, arm = '1;
  logic [NI-1:0] iuv = '0;
  logic fault, latch, s5;
  logic [NO-1:0] roff;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R10";

  always #2 clk = ~clk;

  uvf_supervisor #(.N_OUT(NO), .N_IN(NI), .PERSIST_CYC(P), .INT_PASS(INTP), .SB_MASK(SBM)) dut_i (
    .clk(clk), .rst_n(rst_n), .shdn_i(shdn), .active_i(active), .startup_done_i(sdone),
    .out_uv_i(ouv), .out_armed_i(arm), .in_uv_i(iuv), .temp_warn_i(twarn),
    .temp_crit_i(tcrit), .fault_o(fault), .reg_off_o(roff), .latch_off_o(latch),
    .force_s5_o(s5));

  // Reference model written from the requirements
  int m_ocnt [NO];
  int m_icnt [NI];
  logic [NO-1:0] m_of, m_lat;
  logic [NI-1:0] m_if;
  logic m_latch, m_s5, m_hot, m_trip;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NO; i++) m_ocnt[i] <= 0;
      for (int i = 0; i < NI; i++) m_icnt[i] <= 0;
      m_of <= '0; m_if <= '0; m_lat <= '0;
      m_latch <= 0; m_s5 <= 0; m_hot <= 0; m_trip <= 0;
    end else begin
      for (int i = 0; i < NO; i++) begin
        if (ouv[i] && arm[i]) begin
          m_ocnt[i] <= m_ocnt[i] + 1;
          m_of[i] <= (m_ocnt[i] + 1 >= P);
        end else begin
          m_ocnt[i] <= 0; m_of[i] <= 0;
        end
      end
      for (int i = 0; i < NI; i++) begin
        if (iuv[i]) begin
          m_icnt[i] <= m_icnt[i] + 1;
          m_if[i] <= (m_icnt[i] + 1 >= P);
        end else begin
          m_icnt[i] <= 0; m_if[i] <= 0;
        end
      end
      m_lat <= shdn ? '0 : (m_lat | (m_of & INTP));
      if (!shdn && !sdone && |(m_of & SBM)) m_latch <= 1;
      m_s5 <= (shdn || m_if == '0) ? 1'b0 : (m_s5 | active);
      m_trip <= tcrit | (twarn & m_trip);
      m_hot <= twarn | tcrit;
    end
  end

  function automatic logic exp_fault();
    return !shdn && ((|m_of) || m_latch || m_hot || m_trip || m_s5);
  endfunction

  function automatic logic [NO-1:0] exp_roff();
    return m_lat | {NO{shdn | m_latch | m_trip}};
  endfunction

  task automatic chk(input string req, input string what, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", req, what, got, exp);
    end
  endtask

  task automatic cmp_model();
    chk(tag, "fault_o", NO'(fault), NO'(exp_fault()));
    chk(tag, "reg_off_o", roff, exp_roff());
    chk(tag, "latch_off_o", NO'(latch), NO'(m_latch));
    chk(tag, "force_s5_o", NO'(s5), NO'(m_s5));
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    // R10 reset state
    repeat (2) @(negedge clk);
    chk("R10", "fault_o in reset", NO'(fault), '0);
    chk("R10", "reg_off_o in reset", roff, '0);
    rst_n = 1'b1;
    sdone = 1'b1;
    @(negedge clk);
    chk("R10", "outputs after reset", NO'({fault, latch, s5}), '0);
    chk("R10", "reg_off_o after reset", roff, '0);

    // R1 persistence filter
    tag = "R1";
    ouv[1] = 1; step(P - 1); ouv[1] = 0;
    chk("R1", "short pulse fault_o", NO'(fault), '0);
    step(2);
    ouv[1] = 1; step(P - 1);
    chk("R1", "fault_o one edge early", NO'(fault), '0);
    step(1);
    chk("R1", "fault_o at due edge", NO'(fault), NO'(1));
    ouv[1] = 0; step(1);
    chk("R1", "fault_o after clear", NO'(fault), '0);

    // R2 unarmed rail
    tag = "R2";
    arm[4] = 0; ouv[4] = 1; step(3 * P);
    chk("R2", "unarmed fault_o", NO'(fault), '0);
    chk("R2", "unarmed reg_off_o", roff, '0);
    ouv[4] = 0; arm[4] = 1; step(2);

    // R3 external pass element
    tag = "R3";
    ouv[4] = 1; step(P + 4);
    chk("R3", "external fault_o", NO'(fault), NO'(1));
    chk("R3", "external reg_off_o", roff, '0);
    ouv[4] = 0; step(2);

    // R4 internal pass element latch
    tag = "R4";
    ouv[3] = 1; step(P);
    chk("R4", "reg_off_o same edge as fault", roff, '0);
    step(1);
    chk("R4", "reg_off_o latched", roff, 5'b01000);
    ouv[3] = 0; step(3);
    chk("R4", "latch holds after clear", roff, 5'b01000);

    // R9 shutdown
    tag = "R9";
    ouv[1] = 1; step(P + 1);
    shdn = 1; #1;
    chk("R9", "fault_o immediate", NO'(fault), '0);
    chk("R9", "reg_off_o immediate", roff, '1);
    step(2);
    shdn = 0; ouv[1] = 0; step(2);
    chk("R9", "latches cleared", roff, '0);

    // R6 thermal warning
    tag = "R6";
    twarn = 1; step(1);
    chk("R6", "warn fault_o", NO'(fault), NO'(1));
    step(3);
    chk("R6", "warn reg_off_o", roff, '0);

    // R7 thermal trip with hysteresis
    tag = "R7";
    tcrit = 1; step(1);
    chk("R7", "trip reg_off_o", roff, '1);
    tcrit = 0; step(5);
    chk("R7", "hysteresis hold", roff, '1);
    twarn = 0; step(1);
    chk("R7", "release", roff, '0);
    chk("R7", "fault clear", NO'(fault), '0);

    // R8 input loss
    tag = "R8";
    active = 1; iuv[1] = 1; step(P);
    chk("R8", "force_s5_o early", NO'(s5), '0);
    step(1);
    chk("R8", "force_s5_o set", NO'(s5), NO'(1));
    active = 0; step(4);
    chk("R8", "force_s5_o holds in sleep", NO'(s5), NO'(1));
    iuv[1] = 0; step(2);
    chk("R8", "force_s5_o released", NO'(s5), '0);
    iuv[2] = 1; step(3 * P);
    chk("R8", "sleep input loss", NO'({s5, fault}), '0);
    iuv[2] = 0; active = 1; step(2);

    // R5 start-up latch-off
    tag = "R5";
    rst_n = 0; @(negedge clk); rst_n = 1; sdone = 0;
    ouv[2] = 1; step(P + 1);
    chk("R5", "latch_off_o set", NO'(latch), NO'(1));
    chk("R5", "all regulators off", roff, '1);
    ouv[2] = 0; shdn = 1; step(2); shdn = 0; step(2);
    chk("R5", "latch_off_o survives shutdown", NO'(latch), NO'(1));
    chk("R5", "fault_o while latched", NO'(fault), NO'(1));
    rst_n = 0; @(negedge clk); rst_n = 1; sdone = 1;
    step(1);
    chk("R5", "latch_off_o cleared by reset", NO'(latch), '0);

    // Random traffic checked against the model
    tag = "R1 R3 R4 R5 R7 R8 random";
    for (int s = 0; s < 600; s++) begin
      if ($urandom_range(39) == 0) begin
        rst_n = 0; @(negedge clk); rst_n = 1;
      end
      ouv    = NO'($urandom) & NO'($urandom);
      arm    = ($urandom_range(3) == 0) ? NO'($urandom) : '1;
      iuv    = ($urandom_range(3) == 0) ? NI'($urandom) : '0;
      active = $urandom_range(1);
      sdone  = ($urandom_range(4) != 0);
      shdn   = ($urandom_range(15) == 0);
      tcrit  = ($urandom_range(15) == 0);
      twarn  = tcrit | ($urandom_range(7) == 0);
      step($urandom_range(1, 2 * P));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule